// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the SPI bit clock from the core clock for an SPI shifter. A 16-bit configuration word selects the division ratio. The ratio is built from three parts:

- a 4-bit base divider;
- an optional power-of-two stage whose meaning depends on a mode input;
- an independent power-of-two extra divider.

While a transfer is active, the block drives a registered serial clock. It also emits one-cycle strobes in the first cycle after each rising and each falling serial clock edge, which the shifter uses to launch and capture bits.

The configuration is captured when a transfer starts and is held for the whole transfer. When the transfer request drops, the counters clear and the serial clock returns low. Choosing field values for a wanted bit rate is left to software; only the field decoding and the division hardware are here.

Top module: `sclk_prescaler`

## Requirements
- R1: The base divider is cfg_word[3:0] and gives a factor of 1 to 15; a value of 0 acts as 1.
- R2: With ext_mode low, cfg_word[4] set doubles the base factor, and cfg_word[6] and cfg_word[7] have no effect on the ratio.
- R3: With ext_mode high, the exponent p = {cfg_word[7], cfg_word[6], cfg_word[4]} (bit 7 most significant) multiplies the base factor by 2^p, giving factors of 1 to 128.
- R4: The extra divider exponent s = cfg_word[13:11] multiplies the ratio by 2^s. Codes 5 to 7 act as 4, so the factor ranges from 1 to 16.
- R5: The total ratio N is the product of the base, pre-scale and extra factors. A product of 1 is raised to 2, because a registered clock cannot toggle faster than every core cycle.
- R6: While active, each serial clock period lasts N core cycles: low for N - floor(N/2) cycles and high for floor(N/2) cycles. Odd ratios therefore have the high phase one cycle shorter than the low phase. Each transfer begins with a full low phase.
- R7: sclk_rise is high exactly in the first cycle in which sclk is high after being low. sclk_fall is high exactly in the first cycle in which sclk is low after being high, and this includes a fall caused by ending a transfer.
- R8: One cycle after xfer_active is seen low, sclk is low and the phase counters are cleared. The next transfer then starts with a full low phase.
- R9: The configuration word and ext_mode are sampled when a transfer starts. Changes to them during the transfer have no effect until the next transfer.
- R10: During and just after reset, sclk, sclk_rise and sclk_fall are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Configuration word carrying the divider fields |
| ext_mode | input | 1 | 0: bit 4 doubles; 1: bits 4/6/7 form a pre-scale exponent |
| xfer_active | input | 1 | High while a transfer is in progress |
| sclk | output | 1 | Serial bit clock, idle low |
| sclk_rise | output | 1 | One-cycle strobe after a rising sclk edge |
| sclk_fall | output | 1 | One-cycle strobe after a falling sclk edge |

## Verification
The assertions assume that xfer_active and the configuration inputs are synchronous to clk and that reset is applied before the first transfer. Under these assumptions, the captured ratio is at least 2 and stays fixed for as long as a transfer runs. The phase-length checks measure each segment against that captured ratio rather than against the live configuration, so configuration changes during a transfer are allowed. The stimulus changes the inputs only on falling clock edges, and it holds each configuration for at least one idle cycle before raising xfer_active, so that each transfer starts from a settled state.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  // Configuration word layout
  localparam int CFG_W    = 16;
  localparam int BASE_W   = 4;
  localparam int PRE_W    = 3;
  localparam int DBL_B    = 4;   // doubling bit / exponent bit 0
  localparam int PRE_B1   = 6;   // exponent bit 1
  localparam int PRE_B2   = 7;   // exponent bit 2
  localparam int XDIV_LSB = 11;
  localparam int XDIV_W   = 3;
  localparam int XDIV_MAX = 4;
  // Widest product: 15 * 2^(2^PRE_W-1) * 2^XDIV_MAX
  localparam int RATIO_W  = BASE_W + (1 << PRE_W) - 1 + XDIV_MAX;
  localparam int MIN_RATIO = 2;

  typedef logic [CFG_W-1:0]   cfg_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Pre-scale exponent: simple mode uses only the doubling bit
  function automatic logic [PRE_W-1:0] pre_exp(cfg_t c, logic ext);
    if (ext) return {c[PRE_B2], c[PRE_B1], c[DBL_B]};
    else     return {{(PRE_W-1){1'b0}}, c[DBL_B]};
  endfunction

  // Extra divider exponent, out-of-range codes saturate
  function automatic logic [XDIV_W-1:0] xdiv_exp(cfg_t c);
    logic [XDIV_W-1:0] s;
    s = c[XDIV_LSB +: XDIV_W];
    if (32'(s) > XDIV_MAX) s = XDIV_W'(XDIV_MAX);
    return s;
  endfunction

  function automatic ratio_t base_factor(cfg_t c);
    logic [BASE_W-1:0] b;
    b = c[BASE_W-1:0];
    if (b == '0) b = BASE_W'(1);
    return RATIO_W'(b);
  endfunction

  function automatic ratio_t total_ratio(cfg_t c, logic ext);
    ratio_t r;
    r = base_factor(c) << (32'(pre_exp(c, ext)) + 32'(xdiv_exp(c)));
    if (r < RATIO_W'(MIN_RATIO)) r = RATIO_W'(MIN_RATIO);
    return r;
  endfunction
endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
  import sclk_div_pkg::*;
(
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic               ext_mode,
  output logic [RATIO_W-1:0] ratio
);
  // Bits outside the divider fields are not used here
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[CFG_W-1:XDIV_LSB+XDIV_W],
                             cfg_word[XDIV_LSB-1:PRE_B2+1],
                             cfg_word[DBL_B+1]};

  always_comb ratio = total_ratio(cfg_word, ext_mode);
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
  import sclk_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [RATIO_W-1:0] ratio_now,
  output logic               sclk,
  output logic               rise,
  output logic               fall,
  output logic               run,
  output logic [RATIO_W-1:0] ratio_lat
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half_hi;
  logic [RATIO_W-1:0] half_lo;
  logic               lo_done;   // last low cycle of a period
  logic               hi_done;   // last high cycle of a period

  assign half_hi = ratio_lat >> 1;
  assign half_lo = ratio_lat - half_hi;
  assign lo_done = run && !sclk && (cnt == half_lo - RATIO_W'(1));
  assign hi_done = run &&  sclk && (cnt == half_hi - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      cnt       <= '0;
      sclk      <= 1'b0;
      rise      <= 1'b0;
      fall      <= 1'b0;
      ratio_lat <= RATIO_W'(MIN_RATIO);
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (!active) begin
        run       <= 1'b0;
        cnt       <= '0;
        sclk      <= 1'b0;
        fall      <= sclk;
        ratio_lat <= ratio_now;
      end else if (!run) begin
        run       <= 1'b1;
        cnt       <= '0;
        sclk      <= 1'b0;
        ratio_lat <= ratio_now;
      end else if (lo_done) begin
        sclk <= 1'b1;
        rise <= 1'b1;
        cnt  <= '0;
      end else if (hi_done) begin
        sclk <= 1'b0;
        fall <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + RATIO_W'(1);
      end
    end
  end
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ext_mode,
  input  logic             xfer_active,
  output logic             sclk,
  output logic             sclk_rise,
  output logic             sclk_fall
);
  logic [RATIO_W-1:0] ratio_now;
  logic [RATIO_W-1:0] ratio_lat;
  logic               run;

  sclk_cfg_decode u_dec (
    .cfg_word (cfg_word),
    .ext_mode (ext_mode),
    .ratio    (ratio_now)
  );

  sclk_phase_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (xfer_active),
    .ratio_now (ratio_now),
    .sclk      (sclk),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .run       (run),
    .ratio_lat (ratio_lat)
  );
endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk
  import sclk_div_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               xfer_active,
  input logic               sclk,
  input logic               sclk_rise,
  input logic               sclk_fall,
  input logic               run,
  input logic [RATIO_W-1:0] ratio_lat
);
  logic [RATIO_W-1:0] hi_run;
  logic [RATIO_W-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= sclk ? hi_run + RATIO_W'(1) : '0;
      lo_run <= (sclk || !run) ? '0 : lo_run + RATIO_W'(1);
    end
  end

  // R7
  rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise == $rose(sclk));
  // R7
  fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall == $fell(sclk));
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !sclk);
  // R5
  min_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ratio_lat >= RATIO_W'(MIN_RATIO));
  // R9
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && xfer_active) |=> $stable(ratio_lat));
  // R6
  hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> hi_run < (ratio_lat >> 1));
  // R6
  lo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sclk) |-> lo_run < (ratio_lat - (ratio_lat >> 1)));
endmodule

bind sclk_prescaler sclk_prescaler_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_active (xfer_active),
  .sclk        (sclk),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .run         (run),
  .ratio_lat   (ratio_lat)
);

// File: tb/sclk_prescaler_tb.sv
`timescale 1ns/1ps
module sclk_prescaler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        ext_mode = 1'b0;
  logic        xfer_active = 1'b0;
  logic        sclk, sclk_rise, sclk_fall;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit lvl; int len; string tag; } seg_t;
  seg_t exp_q[$];

  always #2 clk = ~clk;

  sclk_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ext_mode(ext_mode),
    .xfer_active(xfer_active), .sclk(sclk), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall)
  );

  function automatic logic [15:0] mk_cfg(int base, bit b4, bit b6, bit b7, int s);
    logic [15:0] c;
    c = '0;
    c[3:0] = base[3:0];
    c[4] = b4; c[6] = b6; c[7] = b7;
    c[13:11] = s[2:0];
    return c;
  endfunction

  // Expected ratio, restated from the requirements
  function automatic int exp_ratio(logic [15:0] c, bit ext);
    int base, pre, s, n;
    base = (c[3:0] == 0) ? 1 : int'(c[3:0]);
    if (ext) pre = 1 << (int'(c[4]) + 2 * int'(c[6]) + 4 * int'(c[7]));
    else     pre = c[4] ? 2 : 1;
    s = int'(c[13:11]);
    if (s > 4) s = 4;
    n = base * pre * (1 << s);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_periods(int n, int periods, string tag);
    for (int i = 0; i < periods; i++) begin
      exp_q.push_back('{1'b0, n - n / 2, tag});
      exp_q.push_back('{1'b1, n / 2, tag});
    end
  endtask

  task automatic run_xfer(logic [15:0] c, bit ext, int periods, string tag,
                          bit alt, logic [15:0] c2, bit ext2);
    int n;
    @(negedge clk);
    cfg_word = c; ext_mode = ext;
    n = exp_ratio(c, ext);
    push_periods(n, periods, tag);
    @(negedge clk);
    xfer_active = 1'b1;
    if (alt) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      cfg_word = c2; ext_mode = ext2;
      repeat (periods * n - 2) @(posedge clk);
    end else begin
      repeat (periods * n) @(posedge clk);
    end
    @(negedge clk);
    xfer_active = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, tag, "missing sclk edges", exp_q.size(), 0);
    check(sclk == 1'b0, "R8", "sclk after transfer end", int'(sclk), 0);
  endtask

  // Monitor: measures each sclk segment and checks the strobes
  initial begin
    bit prev_s = 0;
    int seg = 0;
    seg_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        check(sclk_rise == (sclk && !prev_s), "R7", "sclk_rise", int'(sclk_rise),
              int'(sclk && !prev_s));
        check(sclk_fall == (!sclk && prev_s), "R7", "sclk_fall", int'(sclk_fall),
              int'(!sclk && prev_s));
        if (sclk != prev_s) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected sclk edge", seg, 0);
          end else begin
            it = exp_q.pop_front();
            check(it.lvl == prev_s, it.tag, "segment level", int'(prev_s), int'(it.lvl));
            check(it.len == seg, it.tag, "segment length", seg, it.len);
          end
          seg = 1;
        end else if (!xfer_active) begin
          seg = 0;
        end else begin
          seg++;
        end
      end
      prev_s = sclk;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(sclk == 0 && sclk_rise == 0 && sclk_fall == 0, "R10", "outputs in reset",
          int'({sclk, sclk_rise, sclk_fall}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk == 0 && sclk_rise == 0 && sclk_fall == 0, "R10", "outputs after reset",
          int'({sclk, sclk_rise, sclk_fall}), 0);

    // R1 base factors, odd ratio phases (R6)
    run_xfer(mk_cfg(5, 0, 0, 0, 0), 0, 3, "R1", 0, '0, 0);
    run_xfer(mk_cfg(15, 0, 0, 0, 0), 0, 2, "R1", 0, '0, 0);
    // R1 zero base acts as 1, R5 product 1 raised to 2
    run_xfer(mk_cfg(0, 0, 0, 0, 0), 0, 4, "R5", 0, '0, 0);
    // R2 doubling, bits 6 and 7 ignored in simple mode (ratio 14)
    run_xfer(mk_cfg(7, 1, 1, 1, 0), 0, 2, "R2", 0, '0, 0);
    run_xfer(mk_cfg(7, 0, 1, 1, 0), 0, 2, "R2", 0, '0, 0);
    // R3 exponent p=5 (ratio 96) and p=7 (ratio 128)
    run_xfer(mk_cfg(3, 1, 0, 1, 0), 1, 2, "R3", 0, '0, 0);
    run_xfer(mk_cfg(1, 1, 1, 1, 0), 1, 2, "R3", 0, '0, 0);
    run_xfer(mk_cfg(9, 0, 1, 0, 0), 1, 2, "R3", 0, '0, 0);
    // R4 extra divider and saturation of codes above 4
    run_xfer(mk_cfg(5, 0, 0, 0, 2), 0, 2, "R4", 0, '0, 0);
    run_xfer(mk_cfg(3, 0, 0, 0, 7), 0, 2, "R4", 0, '0, 0);
    run_xfer(mk_cfg(3, 1, 0, 0, 5), 0, 1, "R4", 0, '0, 0);
    // R5 full product at its largest (30720)
    run_xfer(mk_cfg(15, 1, 1, 1, 4), 1, 1, "R5", 0, '0, 0);
    // R9 configuration change during a transfer has no effect
    run_xfer(mk_cfg(3, 1, 0, 0, 0), 0, 3, "R9", 1, mk_cfg(5, 0, 0, 0, 2), 1);

    // R8 end a transfer while sclk is high (ratio 10, two high cycles seen)
    @(negedge clk);
    cfg_word = mk_cfg(10, 0, 0, 0, 0); ext_mode = 0;
    exp_q.push_back('{1'b0, 5, "R8"});
    exp_q.push_back('{1'b1, 2, "R8"});
    @(negedge clk);
    xfer_active = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk);
    xfer_active = 1'b0;
    @(negedge clk);
    check(sclk == 0, "R8", "sclk one cycle after stop", int'(sclk), 0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8", "aborted segments", exp_q.size(), 0);
    // R8 next transfer starts with a full low phase
    run_xfer(mk_cfg(10, 0, 0, 0, 0), 0, 1, "R8", 0, '0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule